// File: doc/BRIEF.md
# Key-Event Serial Target with Control Register and Event Queue Reader

This block is the two-wire serial (I2C) target of a key-event sensing device. It watches SCL and SDA through a synchronizer running on a fast system clock, at least eight times the SCL rate. It answers only to its own 7-bit address. That address is a fixed 5-bit prefix (binary 01000) followed by two levels taken from strap pins. SDA is driven only as an open-drain enable: when the enable is high the line is pulled low.

A write transaction carries one data byte. That byte sets a small control register, which drives two outputs: a high-impedance request for the sense-drive pin and a soft power-down request.

A read transaction returns a fixed four-byte stream, each byte MSB first:
1. the identity byte, 0x00;
2. the control byte;
3. the key code of the event word at the head of the external queue;
4. the duration code of that same word.

The block pops the queue only when the master acknowledges the duration byte. A master that NACKs the duration byte therefore gets the same event word on the next read.

Top module: `i2c_keyfifo_target`

## Requirements
- R1: The block acknowledges, by pulling SDA low during the ninth clock, an address byte whose upper seven bits equal binary 01000 followed by addr_pins_i[1] then addr_pins_i[0]; the eighth bit is the direction (1 = read, 0 = write).
- R2: After an address byte that does not match, the block leaves SDA released on the ninth clock and for every later clock, and ignores all bytes, until the next START.
- R3: In a write transaction the first data byte is acknowledged and loads control bits 7 and 6; every further data byte in the same transaction is not acknowledged and changes nothing.
- R4: After reset, control bit 7 is 1, control bit 6 is 0, force_hiz_o and pwr_down_o are 0, and SDA is released.
- R5: force_hiz_o is 1 exactly when control bit 7 is 0; pwr_down_o equals control bit 6.
- R6: In the control byte as read, bit 5 is the level of fifo_empty_i and bits 4 to 0 read 0, whatever value was written to those bits.
- R7: A read transaction returns, in this order and MSB first: the identity byte 0x00, the control byte, fifo_key_i, then the duration of the same queue word.
- R8: fifo_pop_o pulses high for exactly one system clock when the master acknowledges the duration byte. A NACK on that byte gives no pulse, so the next read returns the same word.
- R9: After the acknowledge bit of the duration byte, the block releases SDA for the rest of the transaction, so further read bytes are 0xFF.
- R10: A STOP ends any transaction. A repeated START, sent without a STOP, begins a new address phase.
- R11: No pop pulse is issued when fifo_empty_i is high at the acknowledge of the duration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low (open drain) |
| addr_pins_i | input | 2 | Strap levels forming the address LSBs |
| fifo_key_i | input | 8 | Key code of the queue head word |
| fifo_dur_i | input | 8 | Duration code of the queue head word |
| fifo_empty_i | input | 1 | Queue holds no unread word |
| fifo_pop_o | output | 1 | One-cycle request to advance the queue |
| force_hiz_o | output | 1 | Sense-drive pin to high impedance |
| pwr_down_o | output | 1 | Soft power-down and full-reset request |

## Verification
Several kinds of bad internal state show up at the pins within one byte of the bus:
- A corrupted bit counter or shift register would misalign the acknowledge slot, so SDA would read wrong on the ninth clock of the very next byte.
- A wrong byte index would put the control byte or the key code in the wrong slot of the read stream.
- A lost state transition after a NACK or a mismatched address would leave SDA pulled low when the master expects it released. It could also let a later byte alter the control outputs, which are visible as soon as the STOP has been seen.

A pop decision made on the wrong bit or in the wrong phase changes which queue word appears in the following read. The bench therefore counts pop pulses around every read that ends with an acknowledge and every read that ends with a NACK.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_W   = 8;
   localparam int BIT_KEEP = 7;   // control: 1 = sense drive active
   localparam int BIT_PD   = 6;   // control: 1 = power-down request
   localparam int BIT_EMP  = 5;   // control: read-only queue empty

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_IGNORE
   } st_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2ct_sync needs at least two stages");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[0] <= 1'b1;
                  sda_ff[0] <= 1'b1;
               end else begin
                  scl_ff[0] <= scl_i;
                  sda_ff[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[g] <= 1'b1;
                  sda_ff[g] <= 1'b1;
               end else begin
                  scl_ff[g] <= scl_ff[g-1];
                  sda_ff[g] <= sda_ff[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_ff[STAGES-1];
   assign sda_s = sda_ff[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
   import i2ct_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_bits,      // {bit 7, bit 6} of written byte
   input  logic              fifo_empty_i,
   output logic [BYTE_W-1:0] ctrl_byte,
   output logic              force_hiz_o,
   output logic              pwr_down_o
);
   logic keep_q;
   logic pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= 1'b1;
         pd_q   <= 1'b0;
      end else if (wr_en) begin
         keep_q <= wr_bits[1];
         pd_q   <= wr_bits[0];
      end
   end

   always_comb begin
      ctrl_byte           = '0;
      ctrl_byte[BIT_KEEP] = keep_q;
      ctrl_byte[BIT_PD]   = pd_q;
      ctrl_byte[BIT_EMP]  = fifo_empty_i;
   end

   assign force_hiz_o = ~keep_q;
   assign pwr_down_o  = pd_q;

   // R3
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({keep_q, pd_q}) |-> $past(wr_en));
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
#(
   parameter int                ADDR_W  = 7,
   parameter logic [BYTE_W-1:0] ID_BYTE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] ctrl_byte,
   input  logic [BYTE_W-1:0] fifo_key_i,
   input  logic [BYTE_W-1:0] fifo_dur_i,
   input  logic              fifo_empty_i,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [1:0]        wr_bits,
   output logic              fifo_pop
);
   localparam int CNT_W   = $clog2(BYTE_W + 1);
   localparam int LAST_IX = 3;

   st_e               st;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [BYTE_W-1:0] dur_snap;
   logic [CNT_W-1:0]  cnt;
   logic [1:0]        idx;
   logic [1:0]        nxt_idx;
   logic [BYTE_W-1:0] load_byte;
   logic              rw;
   logic              ack_q;

   assign wr_bits = sh[BYTE_W-1 -: 2];

   always_comb begin
      nxt_idx = (st == ST_ADDR_ACK) ? 2'd0 : idx + 2'd1;
      case (nxt_idx)
         2'd0:    load_byte = ID_BYTE;
         2'd1:    load_byte = ctrl_byte;
         2'd2:    load_byte = fifo_key_i;
         default: load_byte = dur_snap;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sh       <= '0;
         tx       <= '0;
         dur_snap <= '0;
         cnt      <= '0;
         idx      <= '0;
         rw       <= 1'b0;
         ack_q    <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         fifo_pop <= 1'b0;
      end else begin
         wr_en    <= 1'b0;
         fifo_pop <= 1'b0;
         if (stop_p) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_p) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                     if (sh[BYTE_W-1:1] == own_addr) begin
                        st     <= ST_ADDR_ACK;
                        sda_oe <= 1'b1;
                        rw     <= sh[0];
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        st     <= ST_RD_DATA;
                        idx    <= nxt_idx;
                        tx     <= load_byte;
                        sda_oe <= ~load_byte[BYTE_W-1];
                     end else begin
                        st     <= ST_WR_DATA;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_WR_DATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                     wr_en  <= 1'b1;
                     sda_oe <= 1'b1;
                     st     <= ST_WR_ACK;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= ST_IGNORE;
                  end
               end
               ST_RD_DATA: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(BYTE_W - 1)) begin
                        sda_oe <= 1'b0;
                        st     <= ST_RD_ACK;
                     end else begin
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     ack_q <= ~sda_s;
                     if (idx == 2'(LAST_IX) && !sda_s && !fifo_empty_i)
                        fifo_pop <= 1'b1;
                  end else if (scl_fall) begin
                     if (ack_q && idx != 2'(LAST_IX)) begin
                        idx    <= nxt_idx;
                        tx     <= load_byte;
                        sda_oe <= ~load_byte[BYTE_W-1];
                        cnt    <= '0;
                        st     <= ST_RD_DATA;
                        if (nxt_idx == 2'd2)
                           dur_snap <= fifo_dur_i;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R8
   pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !fifo_pop);
   // R11
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !$past(fifo_empty_i));
   // R10
   start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_p && !stop_p) |=> (st == ST_ADDR));
   // R2
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE || st == ST_IDLE) |-> !sda_oe);
   // R1
   addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR_ACK) |-> sda_oe);
   // R7
   bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_keyfifo_target.sv
module i2c_keyfifo_target
   import i2ct_pkg::*;
#(
   parameter int                PIN_BITS    = 2,
   parameter int                SYNC_STAGES = 2,
   parameter logic [4:0]        ADDR_PREFIX = 5'b01000,
   parameter logic [BYTE_W-1:0] ID_BYTE     = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [PIN_BITS-1:0] addr_pins_i,
   input  logic [BYTE_W-1:0] fifo_key_i,
   input  logic [BYTE_W-1:0] fifo_dur_i,
   input  logic              fifo_empty_i,
   output logic              fifo_pop_o,
   output logic              force_hiz_o,
   output logic              pwr_down_o
);
   localparam int ADDR_W   = 7;
   localparam int PREFIX_W = ADDR_W - PIN_BITS;

   generate
      if (PREFIX_W != 5) begin : g_bad_split
         $error("prefix plus pin bits must form a 7-bit address");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic              wr_en;
   logic [1:0]        wr_bits;
   logic [BYTE_W-1:0] ctrl_byte;
   logic [ADDR_W-1:0] own_addr;

   assign own_addr = {ADDR_PREFIX, addr_pins_i};

   i2ct_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   i2ct_engine #(.ADDR_W(ADDR_W), .ID_BYTE(ID_BYTE)) i_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .sda_s        (sda_s),
      .start_p      (start_p),
      .stop_p       (stop_p),
      .own_addr     (own_addr),
      .ctrl_byte    (ctrl_byte),
      .fifo_key_i   (fifo_key_i),
      .fifo_dur_i   (fifo_dur_i),
      .fifo_empty_i (fifo_empty_i),
      .sda_oe       (sda_oe_o),
      .wr_en        (wr_en),
      .wr_bits      (wr_bits),
      .fifo_pop     (fifo_pop_o)
   );

   i2ct_ctrl i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_bits      (wr_bits),
      .fifo_empty_i (fifo_empty_i),
      .ctrl_byte    (ctrl_byte),
      .force_hiz_o  (force_hiz_o),
      .pwr_down_o   (pwr_down_o)
   );
endmodule

// File: tb/test_i2c_keyfifo_target.sv
`timescale 1ns/1ps
module test_i2c_keyfifo_target;
   localparam int H = 16;   // SCL half period in system clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] pins = 2'b01;
   logic       sda_oe, pop, fhiz, pdn;
   logic       sda_bus;

   logic [7:0] q_key [4];
   logic [7:0] q_dur [4];
   int         q_rd = 0;
   int         q_cnt = 0;
   int         pops = 0;
   int         errors = 0;
   int         checks = 0;

   logic [7:0] head_key, head_dur;
   logic       q_empty;

   always #4 clk = ~clk;   // 125 MHz

   assign sda_bus  = sda_m & ~sda_oe;
   assign q_empty  = (q_cnt == 0);
   assign head_key = q_empty ? 8'hFF : q_key[q_rd];
   assign head_dur = q_empty ? 8'h00 : q_dur[q_rd];

   i2c_keyfifo_target i_i2c_keyfifo_target (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_bus),
      .sda_oe_o     (sda_oe),
      .addr_pins_i  (pins),
      .fifo_key_i   (head_key),
      .fifo_dur_i   (head_dur),
      .fifo_empty_i (q_empty),
      .fifo_pop_o   (pop),
      .force_hiz_o  (fhiz),
      .pwr_down_o   (pdn)
   );

   always @(posedge clk) begin
      if (pop) begin
         pops <= pops + 1;
         if (q_cnt > 0) begin
            q_rd  <= (q_rd + 1) % 4;
            q_cnt <= q_cnt - 1;
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(H/2);
      scl_m = 1'b1; tick(H/2);
      sda_m = 1'b0; tick(H/2);
      scl_m = 1'b0; tick(H/2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H/2);
      scl_m = 1'b1; tick(H/2);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic xfer_bit(input logic b, output logic r);
      sda_m = b;    tick(H/2);
      scl_m = 1'b1; tick(H/2);
      r = sda_bus;  tick(H/2);
      scl_m = 1'b0; tick(H/2);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) xfer_bit(v[i], r);
      xfer_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic give_ack);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         xfer_bit(1'b1, r);
         v[i] = r;
      end
      xfer_bit(~give_ack, r);
   endtask

   // full read; checks all four bytes against expectations
   task automatic read_all(input string req, input logic [7:0] ectrl,
                           input logic [7:0] ekey, input logic [7:0] edur,
                           input logic ack_last);
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte({5'b01000, pins, 1'b1}, a);
      check("R1 read address ack", {7'd0, a}, 8'd1);
      recv_byte(v, 1'b1); check({req, " R7 id byte"}, v, 8'h00);
      recv_byte(v, 1'b1); check({req, " R6 control byte"}, v, ectrl);
      recv_byte(v, 1'b1); check({req, " R7 key byte"}, v, ekey);
      recv_byte(v, ack_last); check({req, " R7 duration byte"}, v, edur);
   endtask

   task automatic write_ctrl(input logic [7:0] d);
      logic a;
      bus_start();
      send_byte({5'b01000, pins, 1'b0}, a);
      check("R1 write address ack", {7'd0, a}, 8'd1);
      send_byte(d, a);
      check("R3 data byte ack", {7'd0, a}, 8'd1);
      bus_stop();
   endtask

   task automatic t_reset();
      check("R4 force_hiz after reset", {7'd0, fhiz}, 8'd0);
      check("R4 pwr_down after reset", {7'd0, pdn}, 8'd0);
      check("R4 sda released after reset", {7'd0, sda_oe}, 8'd0);
      read_all("R4", 8'hA0, 8'hFF, 8'h00, 1'b0);
      bus_stop();
   endtask

   task automatic t_wrong_addr();
      logic a;
      bus_start();
      send_byte({5'b01000, 2'b10, 1'b0}, a);
      check("R2 mismatch nack", {7'd0, a}, 8'd0);
      send_byte(8'h00, a);
      check("R2 byte after mismatch ignored", {7'd0, a}, 8'd0);
      bus_stop();
      check("R2 control unchanged", {6'd0, fhiz, pdn}, 8'd0);
   endtask

   task automatic t_write();
      write_ctrl(8'h5F);
      tick(4);
      check("R5 force_hiz when bit7=0", {7'd0, fhiz}, 8'd1);
      check("R5 pwr_down when bit6=1", {7'd0, pdn}, 8'd1);
      read_all("R6", 8'h60, 8'hFF, 8'h00, 1'b0);
      bus_stop();
   endtask

   task automatic t_extra_byte();
      logic a;
      bus_start();
      send_byte({5'b01000, pins, 1'b0}, a);
      send_byte(8'h80, a);
      check("R3 first byte ack", {7'd0, a}, 8'd1);
      send_byte(8'h40, a);
      check("R3 second byte nack", {7'd0, a}, 8'd0);
      bus_stop();
      check("R3 second byte not applied", {6'd0, fhiz, pdn}, 8'd0);
   endtask

   task automatic t_fifo_nack();
      int p0;
      q_key[0] = 8'h05; q_dur[0] = 8'h12;
      q_key[1] = 8'h1A; q_dur[1] = 8'h83;
      q_key[2] = 8'hF4; q_dur[2] = 8'h07;
      q_rd = 0; q_cnt = 3;
      p0 = pops;
      read_all("R8 nack", 8'h80, 8'h05, 8'h12, 1'b0);
      bus_stop();
      check("R8 no pop on nack", 8'(pops - p0), 8'd0);
      read_all("R8 repeat", 8'h80, 8'h05, 8'h12, 1'b1);
      bus_stop();
      check("R8 one pop on ack", 8'(pops - p0), 8'd1);
   endtask

   task automatic t_post_stream();
      logic [7:0] v;
      int p0;
      p0 = pops;
      read_all("R7 second word", 8'h80, 8'h1A, 8'h83, 1'b1);
      recv_byte(v, 1'b0);
      check("R9 byte after duration", v, 8'hFF);
      bus_stop();
      check("R9 single pop", 8'(pops - p0), 8'd1);
   endtask

   task automatic t_rep_start();
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte({5'b01000, pins, 1'b0}, a);
      send_byte(8'hC0, a);
      bus_start();
      send_byte({5'b01000, pins, 1'b1}, a);
      check("R10 repeated start address ack", {7'd0, a}, 8'd1);
      recv_byte(v, 1'b1); check("R10 id after repeated start", v, 8'h00);
      recv_byte(v, 1'b0); check("R10 control after repeated start", v, 8'hC0);
      bus_stop();
      check("R5 pwr_down set by write", {6'd0, fhiz, pdn}, 8'd1);
      read_all("R7 third word", 8'hC0, 8'hF4, 8'h07, 1'b1);
      bus_stop();
   endtask

   task automatic t_pop_empty();
      int p0;
      p0 = pops;
      read_all("R11 empty", 8'hE0, 8'hFF, 8'h00, 1'b1);
      bus_stop();
      check("R11 no pop when empty", 8'(pops - p0), 8'd0);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_wrong_addr();
      t_write();
      t_extra_byte();
      t_fifo_nack();
      t_post_stream();
      t_rep_start();
      t_pop_empty();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule